// File: doc/BRIEF.md
# Dual-Width Register Access Bridge

This block sits between a word-addressed host bus and a bank of 512 internal 32-bit registers. The host window spans 1024 consecutive word addresses, and each register occupies one pair of them: register n sits at host address 2n (even) and 2n+1 (odd). Out of reset the host works in half-word mode. In that mode the address parity picks the low or the high 16 bits of the register, and a partial write is merged into the value already stored.

A mode bit lives in a control register. Once software sets it, an even address moves the whole 32-bit word. An odd address keeps its half-word meaning for the upper half. The new mode applies from the access that follows the write that changed it. Reads return their data one cycle after the request.

Top module: `dwreg_bridge`

## Requirements
- R1: After reset the bridge is in half-word mode, every register holds zero and `rd_valid` is low.
- R2: In half-word mode a write to an even address replaces bits 15:0 of the register with `wr_data[15:0]` and leaves bits 31:16 unchanged.
- R3: A write to an odd address, in either mode, replaces bits 31:16 of the register with `wr_data[15:0]` and leaves bits 15:0 unchanged.
- R4: In half-word mode a read of an even address returns bits 15:0 of the register and a read of an odd address returns bits 31:16. The result always sits in `rd_data[15:0]`, and `rd_data[31:16]` is zero.
- R5: In full-word mode a write to an even address stores all 32 bits of `wr_data`, and a read of an even address returns all 32 bits.
- R6: In full-word mode a read of an odd address returns bits 31:16 of the register in `rd_data[15:0]` and zero in `rd_data[31:16]`.
- R7: Bit 0 of register 64 (host addresses 128 and 129) selects full-word mode when it is 1. A change to this bit governs the next access and every later one.
- R8: A read accepted on a clock edge drives `rd_valid` high for exactly one cycle after that edge and puts the result on `rd_data`. In any other cycle `rd_valid` is low and `rd_data` holds its last value.
- R9: Register n maps to host addresses 2n and 2n+1. A write to one register never changes any other register, including the lowest (0) and the highest (511).
- R10: When `host_valid` is low, no register changes, whatever the values of `host_we`, `host_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_valid | input | 1 | Request strobe; one access per cycle when high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host word address; bits 9:1 give the register, bit 0 gives the half |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a new read result |

## Verification
The assertions assume the host makes at most one access per cycle and that `host_valid`, `host_we` and `host_addr` are known whenever reset is inactive. They also assume no request arrives while the internal reset synchronizer still holds the block in reset. The bench drives every input on the falling edge and holds idle cycles with `host_valid` low. It issues its first request several cycles after reset is released, so the request never coincides with the synchronizer release. The stress on `host_we` and `wr_data` with `host_valid` low probes R10 without ever breaking the one-access-per-cycle assumption.

// File: rtl/dwreg_pkg.sv
package dwreg_pkg;

  typedef enum logic [1:0] {
    ACC_LO   = 2'd0,
    ACC_HI   = 2'd1,
    ACC_FULL = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/dwreg_decode.sv
module dwreg_decode
  import dwreg_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide_mode,
  output logic [IDX_W-1:0]  idx,
  output acc_kind_e         kind
);

  always_comb begin
    idx = addr[ADDR_W-1:1];
    if (addr[0]) begin
      kind = ACC_HI;
    end else if (wide_mode) begin
      kind = ACC_FULL;
    end else begin
      kind = ACC_LO;
    end
  end

endmodule

// File: rtl/dwreg_merge.sv
module dwreg_merge
  import dwreg_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] rd_fmt
);

  always_comb begin
    unique case (kind)
      ACC_LO: begin
        new_val = {old_val[DATA_W-1:HALF_W], wr_data[HALF_W-1:0]};
        rd_fmt  = {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
      end
      ACC_HI: begin
        new_val = {wr_data[HALF_W-1:0], old_val[HALF_W-1:0]};
        rd_fmt  = {{HALF_W{1'b0}}, old_val[DATA_W-1:HALF_W]};
      end
      default: begin
        new_val = wr_data;
        rd_fmt  = old_val;
      end
    endcase
  end

endmodule

// File: rtl/dwreg_bank.sv
module dwreg_bank #(
  parameter int DATA_W   = 32,
  parameter int NREG     = 512,
  parameter int CTRL_IDX = 64,
  parameter int MODE_BIT = 0,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_val,
  output logic              wide_mode
);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wr_val;
      end
    end
  end

  assign rd_val    = regs_q[idx];
  assign wide_mode = regs_q[CTRL_IDX][MODE_BIT];

endmodule

// File: rtl/dwreg_bridge.sv
module dwreg_bridge
  import dwreg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int CTRL_IDX = 64,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int IDX_W = ADDR_W - 1;
  localparam int NREG  = 1 << IDX_W;

  // reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  logic              wide_mode;
  logic [IDX_W-1:0]  idx;
  acc_kind_e         kind;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] new_val;
  logic [DATA_W-1:0] rd_fmt;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = host_valid && host_we;
  assign rd_en = host_valid && !host_we;

  dwreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (host_addr),
    .wide_mode (wide_mode),
    .idx       (idx),
    .kind      (kind)
  );

  dwreg_bank #(
    .DATA_W   (DATA_W),
    .NREG     (NREG),
    .CTRL_IDX (CTRL_IDX),
    .MODE_BIT (MODE_BIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .idx       (idx),
    .wr_val    (new_val),
    .rd_val    (cur_val),
    .wide_mode (wide_mode)
  );

  dwreg_merge #(.DATA_W(DATA_W)) u_merge (
    .kind    (kind),
    .old_val (cur_val),
    .wr_data (wr_data),
    .new_val (new_val),
    .rd_fmt  (rd_fmt)
  );

  // read return path: next-state and register split
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_valid_d;

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_data;
    if (rd_en) begin
      rd_data_d = rd_fmt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_valid <= rd_valid_d;
    end
  end

endmodule

// File: rtl/dwreg_bridge_chk.sv
module dwreg_bridge_chk #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int CTRL_IDX = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              host_valid,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              wide_mode
);

  localparam int HALF_W = DATA_W / 2;

  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_valid && !host_we) |=> rd_valid);

  a_r8_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(host_valid && !host_we) |=> !rd_valid);

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(host_valid && !host_we) |=> $stable(rd_data));

  a_r4_half_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_valid && !host_we && (!wide_mode || host_addr[0]))
      |=> (rd_data[DATA_W-1:HALF_W] == '0));

  a_r7_mode_only_by_ctrl_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(host_valid && host_we && (host_addr[ADDR_W-1:1] == (ADDR_W-1)'(CTRL_IDX))
      && !host_addr[0]) |=> $stable(wide_mode));

  a_r10_idle_keeps_mode: assert property (@(posedge clk) disable iff (!rst_q_n)
    !host_valid |=> $stable(wide_mode));

endmodule

bind dwreg_bridge dwreg_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_IDX (CTRL_IDX)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .host_valid (host_valid),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .wide_mode  (wide_mode)
);

// File: tb/dwreg_bridge_bench.sv
`timescale 1ns/1ps
module dwreg_bridge_bench;

  logic        clk;
  logic        rst_n;
  logic        host_valid;
  logic        host_we;
  logic [9:0]  host_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks;
  int errors;
  bit done;

  dwreg_bridge u_dwreg_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; wr_data = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = a; wr_data = 32'h0;
    @(negedge clk);
    host_valid = 1'b0;
    check(rd_valid === 1'b1, req, {31'b0, rd_valid}, 32'h1);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset;
    check(rd_valid === 1'b0, "R1", {31'b0, rd_valid}, 32'h0);
    rd_chk(10'd0, 32'h0, "R1");
    rd_chk(10'd1023, 32'h0, "R1");
    rd_chk(10'd128, 32'h0, "R1");
    rd_chk(10'd20, 32'h0, "R1");
  endtask

  task automatic t_half_words;
    wr(10'd10, 32'hAAAA_1234);
    rd_chk(10'd10, 32'h0000_1234, "R2");
    rd_chk(10'd11, 32'h0000_0000, "R4");
    wr(10'd11, 32'h5555_BEEF);
    rd_chk(10'd11, 32'h0000_BEEF, "R3");
    rd_chk(10'd10, 32'h0000_1234, "R3");
    wr(10'd10, 32'h0000_CAFE);
    rd_chk(10'd11, 32'h0000_BEEF, "R2");
    rd_chk(10'd10, 32'h0000_CAFE, "R4");
  endtask

  task automatic t_neighbours;
    wr(10'd12, 32'h0000_1111);
    wr(10'd1023, 32'h0000_7777);
    wr(10'd0, 32'h0000_3333);
    rd_chk(10'd10, 32'h0000_CAFE, "R9");
    rd_chk(10'd11, 32'h0000_BEEF, "R9");
    rd_chk(10'd1022, 32'h0000_0000, "R9");
    rd_chk(10'd1023, 32'h0000_7777, "R9");
    rd_chk(10'd1, 32'h0000_0000, "R9");
    rd_chk(10'd0, 32'h0000_3333, "R9");
  endtask

  task automatic t_latency_and_idle;
    // write cycle produces no read return; rd_data keeps last read (3333)
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = 10'd12; wr_data = 32'h0000_2222;
    @(negedge clk);
    host_valid = 1'b0;
    check(rd_valid === 1'b0, "R8", {31'b0, rd_valid}, 32'h0);
    check(rd_data === 32'h0000_3333, "R8", rd_data, 32'h0000_3333);
    // idle cycles with write-looking inputs
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b1; host_addr = 10'd10; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    host_addr = 10'd128;
    @(negedge clk);
    host_we = 1'b0;
    check(rd_valid === 1'b0, "R10", {31'b0, rd_valid}, 32'h0);
    rd_chk(10'd10, 32'h0000_CAFE, "R10");
    rd_chk(10'd12, 32'h0000_2222, "R10");
    rd_chk(10'd128, 32'h0000_0000, "R10");
  endtask

  task automatic t_wide_mode;
    wr(10'd128, 32'h0000_0001);
    rd_chk(10'd10, 32'hBEEF_CAFE, "R7");
    wr(10'd20, 32'hDEAD_BEEF);
    rd_chk(10'd20, 32'hDEAD_BEEF, "R5");
    rd_chk(10'd21, 32'h0000_DEAD, "R6");
    wr(10'd21, 32'h9999_0042);
    rd_chk(10'd20, 32'h0042_BEEF, "R3");
    rd_chk(10'd128, 32'h0000_0001, "R7");
    wr(10'd128, 32'h0000_0000);
    rd_chk(10'd20, 32'h0000_BEEF, "R7");
    rd_chk(10'd21, 32'h0000_0042, "R4");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    host_valid = 1'b0; host_we = 1'b0; host_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_half_words;
    t_neighbours;
    t_latency_and_idle;
    t_wide_mode;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule